// File: doc/BRIEF.md
# Counter-Fed Scratch Memory Exerciser

This block is a self-contained memory exerciser. A 16-bit program counter supplies both an address and a data word. Its low four bits pass through a binary-to-one-hot decoder, giving a 16-bit word with exactly one line set. A one-bit phase signal drives a demultiplexor. The demultiplexor sends that one-hot word either to the write enables or to the read selects of a 16-entry by 16-bit register file.

The block alternates between two phases. In the write phase, the current counter value is stored in the entry that the counter's low bits select. In the read phase that follows, the same entry is read back through a registered output port. The counter moves forward by one only after each write-then-read pair. This way every address is stored and then checked in turn, and the sequence wraps through the whole 16-bit range.

The block has no data inputs. Surrounding logic or a tester observes the counter, the phase, both select groups and the read port to confirm that the decoder, the demux and the storage work together.

Top module: `pc_scratch_mem`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the block clears the counter to 0, sets the phase to write (`mode_o` = 0) and drives `rvalid_o` and `rdata_o` to 0.
- R2: The phase flips on every clock edge out of reset. Write (0) is always followed by read (1), and read is always followed by write.
- R3: The counter keeps its value across a write-phase edge. It increases by exactly 1, modulo 2^16, at a read-phase edge, so 0xFFFF is followed by 0x0000.
- R4: The active select group carries exactly one set bit, at position `pc_o[3:0]`.
- R5: The inactive select group is all zero. `rsel_o` is 0 in the write phase and `wsel_o` is 0 in the read phase.
- R6: At a write-phase edge, the register file stores the current counter value in entry `pc_o[3:0]`. No other entry changes.
- R7: The read port is registered. In the cycle after a read phase, `rvalid_o` is 1 and `rdata_o` equals the counter value of that read phase, which is the value written one cycle before it.
- R8: In the cycle after a write phase, `rvalid_o` is 0 and `rdata_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_o | output | 16 | Current counter value |
| mode_o | output | 1 | Phase: 0 = write, 1 = read |
| wsel_o | output | 16 | One-hot write enables into the register file |
| rsel_o | output | 16 | One-hot read selects into the register file |
| rdata_o | output | 16 | Registered read data |
| rvalid_o | output | 1 | High in the cycle after a read phase |

## Verification
The assertions check, on every cycle, the alternation of phases, the hold-then-step pattern of the counter, the one-hot shape of the active select group, the zeroed idle group, and the rule that a read returns the counter value of its phase one cycle later. Only the bench scenarios can show the reset values and a reset applied in the middle of a run. They also show the wrap from 0xFFFF to 0, and that entries are rewritten correctly when the counter revisits them, since the bench sweeps all 65536 counter values and checks each readback against an expected value it computes itself.

// File: rtl/pcm_pkg.sv
// Package: shared phase encoding for the counter-fed scratch memory.
// Assumes a single-bit phase, with write encoded as 0.
package pcm_pkg;
    typedef enum logic {
        PH_WRITE = 1'b0,
        PH_READ  = 1'b1
    } phase_t;
endpackage

// File: rtl/pcm_counter.sv
// Module: pcm_counter
// Holds the counter and the write/read phase. The phase flips every cycle.
// The counter steps only at the end of a read phase.
// Assumes a synchronous active-low reset.
module pcm_counter
    import pcm_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] pc,
    output phase_t          phase
);
    // Phase toggle and counter advance after each write/read pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            phase <= PH_WRITE;
        end else if (phase == PH_READ) begin
            pc    <= pc + 1'b1;
            phase <= PH_WRITE;
        end else begin
            phase <= PH_READ;
        end
    end
endmodule

// File: rtl/pcm_decoder.sv
// Module: pcm_decoder
// Binary-to-one-hot decoder. Purely combinational.
// Assumes ENTRIES == 2**IDX_W, so every index value maps to a line.
module pcm_decoder #(
    parameter  int IDX_W   = 4,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic [IDX_W-1:0]   idx,
    output logic [ENTRIES-1:0] onehot
);
    // One comparator per output line.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_line
        assign onehot[i] = (idx == IDX_W'(i));
    end
endmodule

// File: rtl/pcm_demux.sv
// Module: pcm_demux
// Routes a select word to the write group or the read group, depending on
// the phase. The group that is not chosen is driven to all zeros.
module pcm_demux
    import pcm_pkg::*;
#(
    parameter int N = 16
) (
    input  phase_t       phase,
    input  logic [N-1:0] sel,
    output logic [N-1:0] wsel,
    output logic [N-1:0] rsel
);
    // Per-line gating, one pair of AND gates per select line.
    for (genvar i = 0; i < N; i++) begin : g_route
        assign wsel[i] = sel[i] & (phase == PH_WRITE);
        assign rsel[i] = sel[i] & (phase == PH_READ);
    end
endmodule

// File: rtl/pcm_regfile.sv
// Module: pcm_regfile
// Behavioural register file with one-hot write enables and one-hot read
// selects. The read data is registered; rvalid follows any read select.
// Assumes at most one write enable and at most one read select are set.
// The storage itself is not reset.
module pcm_regfile #(
    parameter int DATA_W  = 16,
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] we,
    input  logic [ENTRIES-1:0] re,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               rvalid
);
    logic [DATA_W-1:0] mem [ENTRIES];
    logic [DATA_W-1:0] rd_mux;

    // Storage: each entry loads when its own enable is set.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (we[i]) mem[i] <= wdata;
        end
    end

    // One-hot read mux, built as an AND-OR tree.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            rd_mux = rd_mux | (re[i] ? mem[i] : '0);
        end
    end

    // Output register: capture on a read, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= |re;
            if (|re) rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/pc_scratch_mem.sv
// Module: pc_scratch_mem (top)
// Counter-fed scratch memory exerciser. Decodes the counter's low bits to one
// line, routes that line to the write or read group by phase, stores the
// counter value and reads it back one phase later.
// Assumes IDX_W <= PC_W.
module pc_scratch_mem
    import pcm_pkg::*;
#(
    parameter  int PC_W    = 16,
    parameter  int IDX_W   = 4,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PC_W-1:0]    pc_o,
    output logic               mode_o,
    output logic [ENTRIES-1:0] wsel_o,
    output logic [ENTRIES-1:0] rsel_o,
    output logic [PC_W-1:0]    rdata_o,
    output logic               rvalid_o
);
    phase_t             phase;
    logic [ENTRIES-1:0] onehot;

    pcm_counter #(.PC_W(PC_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .pc    (pc_o),
        .phase (phase)
    );

    pcm_decoder #(.IDX_W(IDX_W)) u_dec (
        .idx    (pc_o[IDX_W-1:0]),
        .onehot (onehot)
    );

    pcm_demux #(.N(ENTRIES)) u_dmx (
        .phase (phase),
        .sel   (onehot),
        .wsel  (wsel_o),
        .rsel  (rsel_o)
    );

    pcm_regfile #(.DATA_W(PC_W), .ENTRIES(ENTRIES)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wsel_o),
        .re     (rsel_o),
        .wdata  (pc_o),
        .rdata  (rdata_o),
        .rvalid (rvalid_o)
    );

    assign mode_o = phase;
endmodule

// File: rtl/pcm_checker.sv
// Module: pcm_checker
// Temporal checks on the exerciser's ports. Bound to pc_scratch_mem.
module pcm_checker #(
    parameter  int PC_W    = 16,
    parameter  int IDX_W   = 4,
    localparam int ENTRIES = 1 << IDX_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    pc_o,
    input logic               mode_o,
    input logic [ENTRIES-1:0] wsel_o,
    input logic [ENTRIES-1:0] rsel_o,
    input logic [PC_W-1:0]    rdata_o,
    input logic               rvalid_o
);
    p_wr_to_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o |=> mode_o);
    p_rd_to_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |=> !mode_o);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o |=> $stable(pc_o));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |=> pc_o == PC_W'($past(pc_o) + 1'b1));
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wsel_o | rsel_o) == 1);
    p_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((wsel_o | rsel_o) >> pc_o[IDX_W-1:0]) == ENTRIES'(1));
    p_rd_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o |-> rsel_o == '0);
    p_wr_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |-> wsel_o == '0);
    p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |=> rvalid_o && rdata_o == $past(pc_o));
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o |=> !rvalid_o && $stable(rdata_o));
endmodule

bind pc_scratch_mem pcm_checker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_o     (pc_o),
    .mode_o   (mode_o),
    .wsel_o   (wsel_o),
    .rsel_o   (rsel_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
);

// File: tb/pc_scratch_mem_test.sv
// Bench: resets the block, runs a while, resets again in the middle of the
// run, then sweeps every counter value plus a wrap. Outputs are sampled at
// falling edges.
module pc_scratch_mem_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_o, wsel_o, rsel_o, rdata_o;
    logic        mode_o, rvalid_o;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    pc_scratch_mem uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pc_o     (pc_o),
        .mode_o   (mode_o),
        .wsel_o   (wsel_o),
        .rsel_o   (rsel_o),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_reset();
        chk(pc_o == 16'h0, "R1 pc", 32'(pc_o), 32'h0);
        chk(mode_o == 1'b0, "R1 mode", 32'(mode_o), 32'h0);
        chk(rvalid_o == 1'b0, "R1 rvalid", 32'(rvalid_o), 32'h0);
        chk(rdata_o == 16'h0, "R1 rdata", 32'(rdata_o), 32'h0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] exp_pc;
        logic [15:0] prev_rd;
        repeat (3) @(negedge clk);
        chk_reset();
        rst_n = 1'b1;
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset();               // R1 mid-run reset
        rst_n = 1'b1;
        exp_pc  = 16'h0;
        prev_rd = 16'h0;
        for (int i = 0; i < 65536 + 4; i++) begin
            // Write phase.
            chk(mode_o == 1'b0, "R2 write phase", 32'(mode_o), 32'h0);
            chk(pc_o == exp_pc, "R3 pc in write", 32'(pc_o), 32'(exp_pc));
            chk(wsel_o == (16'h1 << exp_pc[3:0]), "R4 wsel",
                32'(wsel_o), 32'(16'h1 << exp_pc[3:0]));
            chk(rsel_o == 16'h0, "R5 rsel idle", 32'(rsel_o), 32'h0);
            if (i > 0) begin
                chk(rvalid_o == 1'b1, "R7 rvalid", 32'(rvalid_o), 32'h1);
                chk(rdata_o == 16'(exp_pc - 1'b1), "R6 R7 readback",
                    32'(rdata_o), 32'(16'(exp_pc - 1'b1)));
            end else begin
                chk(rvalid_o == 1'b0, "R1 first rvalid", 32'(rvalid_o), 32'h0);
            end
            prev_rd = rdata_o;
            @(negedge clk);
            // Read phase.
            chk(mode_o == 1'b1, "R2 read phase", 32'(mode_o), 32'h1);
            chk(pc_o == exp_pc, "R3 pc held", 32'(pc_o), 32'(exp_pc));
            chk(rsel_o == (16'h1 << exp_pc[3:0]), "R4 rsel",
                32'(rsel_o), 32'(16'h1 << exp_pc[3:0]));
            chk(wsel_o == 16'h0, "R5 wsel idle", 32'(wsel_o), 32'h0);
            chk(rvalid_o == 1'b0, "R8 rvalid low", 32'(rvalid_o), 32'h0);
            chk(rdata_o == prev_rd, "R8 rdata held", 32'(rdata_o), 32'(prev_rd));
            exp_pc = exp_pc + 1'b1;    // R3 wraps modulo 2^16
            @(negedge clk);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule